// File: doc/BRIEF.md
# Sequential Booth Signed Multiplier

This block multiplies two two's-complement operands of `WIDTH` bits over several clock cycles and returns their full `2*WIDTH`-bit signed product. A request is made by raising `startReq` for one cycle while the block is idle. The operands are captured at that edge, and the block then works through one multiplier bit per cycle. Each cycle it looks at a pair of adjacent multiplier bits. A run of ones in the multiplier costs one subtraction where the run begins and one addition just past its end. Every other position costs no arithmetic at all.

The working register is `2*WIDTH+1` bits wide. The upper `WIDTH` bits hold the running partial product. The lower `WIDTH` bits start out holding the multiplier, and below them sits one extra bit that is zero at load. Each step adds, subtracts or skips the multiplicand into the upper part only. The whole register then shifts right by one place arithmetically. Because the sign bit is replicated on every shift, operands of either sign need no conversion before or after the operation. When the last step completes, `done` pulses for one cycle. The product is split into `prodHi` and `prodLo` and stays there until the next request is accepted.

Top module: `seq_booth_mul`

## Requirements
- R1: While `rstN` is low and after its release, `busy`, `done`, `prodHi` and `prodLo` are all zero until a request is accepted.
- R2: A high `startReq` sampled at a rising edge while `busy` is low is accepted, and `busy` is high in the following cycle.
- R3: For a request accepted at edge k, `busy` is high for exactly `WIDTH` cycles (after edges k through k+WIDTH-1), and `done` is high for the one cycle after edge k+WIDTH.
- R4: While `done` is high, `{prodHi, prodLo}` equals the two's-complement product of the captured operands, taken modulo 2^(2*WIDTH). Both operands are interpreted as signed `WIDTH`-bit values.
- R5: While `busy` is high, `startReq`, `mcand` and `mplier` have no effect. The result and the timing of the operation in progress are unchanged.
- R6: Operands equal to the most negative value give exact results, for example (-2^(WIDTH-1)) x (-2^(WIDTH-1)) = 2^(2*WIDTH-2) and (-2^(WIDTH-1)) x 1.
- R7: `done` is never high in two consecutive cycles, and `done` and `busy` are never high together.
- R8: A request raised in the cycle where `done` is high is accepted. `busy` rises in the next cycle and `done` falls.
- R9: When `busy` is low and no request is accepted, `prodHi` and `prodLo` keep their values into the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startReq | input | 1 | Request a multiplication; taken only when idle |
| mcand | input | WIDTH | Signed multiplicand, captured on acceptance |
| mplier | input | WIDTH | Signed multiplier, captured on acceptance |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle pulse when the product is ready |
| prodHi | output | WIDTH | Upper half of the signed product |
| prodLo | output | WIDTH | Lower half of the signed product |

## Verification
Two events can fall in the same cycle: the completion pulse of one operation and the acceptance of the next request. The bench provokes this by raising `startReq` with fresh operands during the very cycle in which `done` is high. The finished product must still be visible in that cycle. After the following edge, `done` must drop and `busy` must rise. The reference model in the bench predicts `busy`, `done` and the idle product every cycle. It catches any lost request, doubled pulse or corrupted result at this boundary, and also when requests are repeated while an operation is in progress.

// File: rtl/booth_pkg.sv
package booth_pkg;

  // Arithmetic selected for one step from the examined bit pair
  typedef enum logic [1:0] {
    OP_NONE = 2'b00,
    OP_ADD  = 2'b01,
    OP_SUB  = 2'b10
  } boothOp_t;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic load;   // capture operands and initialise the working register
    logic step;   // perform one recode / add-sub / shift iteration
  } boothStrobes_t;

  // Radix-2 recoding: {current lsb, bit to its right}
  function automatic boothOp_t recodePair(input logic [1:0] pair);
    case (pair)
      2'b10:   recodePair = OP_SUB;  // first one of a run
      2'b01:   recodePair = OP_ADD;  // first zero after a run
      default: recodePair = OP_NONE; // inside a run of zeros or ones
    endcase
  endfunction

endpackage

// File: rtl/booth_ctrl.sv
module booth_ctrl
  import booth_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          startReq,
  output boothStrobes_t strobes,
  output logic          busy,
  output logic          done
);

  localparam int CW = $clog2(WIDTH + 1);
  localparam logic [CW-1:0] LAST_STEP = CW'(WIDTH - 1);

  typedef enum logic {S_IDLE, S_RUN} ctrlState_t;

  ctrlState_t     stateQ;
  logic [CW-1:0]  stepCnt;
  logic           doneQ;
  logic           accept;
  logic           lastStep;

  assign accept   = startReq && (stateQ == S_IDLE);
  assign lastStep = (stateQ == S_RUN) && (stepCnt == LAST_STEP);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ  <= S_IDLE;
      stepCnt <= '0;
      doneQ   <= 1'b0;
    end else begin
      doneQ <= lastStep;
      case (stateQ)
        S_IDLE: begin
          if (accept) begin
            stateQ  <= S_RUN;
            stepCnt <= '0;
          end
        end
        S_RUN: begin
          if (lastStep) begin
            stateQ  <= S_IDLE;
            stepCnt <= '0;
          end else begin
            stepCnt <= stepCnt + 1'b1;
          end
        end
        default: stateQ <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    strobes      = '0;
    strobes.load = accept;
    strobes.step = (stateQ == S_RUN);
  end

  assign busy = (stateQ == S_RUN);
  assign done = doneQ;

endmodule

// File: rtl/booth_datapath.sv
module booth_datapath
  import booth_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  boothStrobes_t      strobes,
  input  logic [WIDTH-1:0]   mcand,
  input  logic [WIDTH-1:0]   mplier,
  output logic [WIDTH-1:0]   prodHi,
  output logic [WIDTH-1:0]   prodLo
);

  localparam int REG_W = 2 * WIDTH + 1;  // product plus the appended low bit
  localparam int ADD_W = WIDTH + 1;      // one guard bit keeps the sign

  logic [REG_W-1:0] workQ;
  logic [WIDTH-1:0] mcandQ;
  logic [ADD_W-1:0] upperExt;
  logic [ADD_W-1:0] mcandExt;
  logic [ADD_W-1:0] stepSum;
  boothOp_t         stepOp;

  assign upperExt = {workQ[REG_W-1], workQ[REG_W-1 -: WIDTH]};
  assign mcandExt = {mcandQ[WIDTH-1], mcandQ};
  assign stepOp   = recodePair(workQ[1:0]);

  always_comb begin
    case (stepOp)
      OP_ADD:  stepSum = upperExt + mcandExt;
      OP_SUB:  stepSum = upperExt - mcandExt;
      default: stepSum = upperExt;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      workQ  <= '0;
      mcandQ <= '0;
    end else if (strobes.load) begin
      workQ  <= {{WIDTH{1'b0}}, mplier, 1'b0};
      mcandQ <= mcand;
    end else if (strobes.step) begin
      // guard bit of the sum becomes the replicated sign after the shift
      workQ <= {stepSum, workQ[WIDTH:1]};
    end
  end

  assign prodHi = workQ[REG_W-1 -: WIDTH];
  assign prodLo = workQ[WIDTH:1];

endmodule

// File: rtl/seq_booth_mul.sv
module seq_booth_mul
  import booth_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  input  logic [WIDTH-1:0] mcand,
  input  logic [WIDTH-1:0] mplier,
  output logic             busy,
  output logic             done,
  output logic [WIDTH-1:0] prodHi,
  output logic [WIDTH-1:0] prodLo
);

  boothStrobes_t strobes;

  booth_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .startReq (startReq),
    .strobes  (strobes),
    .busy     (busy),
    .done     (done)
  );

  booth_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .mcand   (mcand),
    .mplier  (mplier),
    .prodHi  (prodHi),
    .prodLo  (prodLo)
  );

endmodule

// File: rtl/seq_booth_mul_chk.sv
module seq_booth_mul_chk #(
  parameter int WIDTH = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             startReq,
  input logic [WIDTH-1:0] mcand,
  input logic [WIDTH-1:0] mplier,
  input logic             busy,
  input logic             done,
  input logic [WIDTH-1:0] prodHi,
  input logic [WIDTH-1:0] prodLo
);

  localparam int CW = $clog2(WIDTH + 1) + 1;
  localparam logic [CW-1:0] RUN_LEN = CW'(WIDTH);

  logic [CW-1:0]        runLen;
  logic [WIDTH-1:0]     opA;
  logic [WIDTH-1:0]     opB;
  logic [2*WIDTH-1:0]   extA;
  logic [2*WIDTH-1:0]   extB;
  logic [2*WIDTH-1:0]   expProd;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runLen <= '0;
      opA    <= '0;
      opB    <= '0;
    end else begin
      runLen <= busy ? runLen + 1'b1 : '0;
      if (startReq && !busy) begin
        opA <= mcand;
        opB <= mplier;
      end
    end
  end

  assign extA    = {{WIDTH{opA[WIDTH-1]}}, opA};
  assign extB    = {{WIDTH{opB[WIDTH-1]}}, opB};
  assign expProd = extA * extB;

  AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rstN)
    (startReq && !busy) |=> busy) else $error("start not taken"); // R2

  AST_RUN_LENGTH: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (done && runLen == RUN_LEN)) else $error("bad run length"); // R3

  AST_PRODUCT_OK: assert property (@(posedge clk) disable iff (!rstN)
    done |-> ({prodHi, prodLo} == expProd)) else $error("wrong product"); // R4

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done) else $error("done longer than one cycle"); // R7

  AST_DONE_EXCL_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    !(done && busy)) else $error("done with busy"); // R7

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !startReq) |=> $stable({prodHi, prodLo})) else $error("idle product moved"); // R9

endmodule

bind seq_booth_mul seq_booth_mul_chk #(.WIDTH(WIDTH)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .startReq (startReq),
  .mcand    (mcand),
  .mplier   (mplier),
  .busy     (busy),
  .done     (done),
  .prodHi   (prodHi),
  .prodLo   (prodLo)
);

// File: tb/seq_booth_mul_bench.sv
module seq_booth_mul_bench;

  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         startReq = 1'b0;
  logic [W-1:0] mcand = '0;
  logic [W-1:0] mplier = '0;
  logic         busy;
  logic         done;
  logic [W-1:0] prodHi;
  logic [W-1:0] prodLo;

  int compared = 0;
  int mismatched = 0;
  bit running = 1'b0;
  string phaseTag = "R4";

  // behavioural reference state
  bit             busyM = 1'b0;
  bit             doneM = 1'b0;
  int             remain = 0;
  logic [2*W-1:0] resM = '0;
  logic [2*W-1:0] pendM = '0;

  always #2.5 clk = ~clk;  // 200 MHz

  seq_booth_mul #(.WIDTH(W)) u_seq_booth_mul (
    .clk(clk), .rstN(rstN), .startReq(startReq), .mcand(mcand), .mplier(mplier),
    .busy(busy), .done(done), .prodHi(prodHi), .prodLo(prodLo)
  );

  function automatic logic [2*W-1:0] refProduct(input logic [W-1:0] a, input logic [W-1:0] b);
    longint sa, sb, p;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    p  = sa * sb;
    return p[2*W-1:0];
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      busyM = 1'b0; doneM = 1'b0; remain = 0; resM = '0; pendM = '0;
    end else begin
      doneM = 1'b0;
      if (busyM) begin
        remain = remain - 1;
        if (remain == 0) begin
          busyM = 1'b0; doneM = 1'b1; resM = pendM;
        end
      end else if (startReq) begin
        busyM = 1'b1; remain = W; pendM = refProduct(mcand, mplier);
      end
    end
  end

  task automatic check(input string tag, input string what, input longint act, input longint exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  // compare every cycle away from the rising edge
  always @(negedge clk) begin
    if (running && rstN) begin
      check(phaseTag, "busy (R3)", busy, busyM);
      check(phaseTag, "done (R3/R7)", done, doneM);
      if (!busyM) check(phaseTag, "product (R4/R9)", {prodHi, prodLo}, resM);
    end
  end

  task automatic waitDone();
    int guard = 0;
    while (!done && guard < 50) begin
      @(negedge clk);
      guard++;
    end
  endtask

  // issue a request; when 'now' is set, raise it in the current cycle
  task automatic doOp(input logic [W-1:0] a, input logic [W-1:0] b, input bit now);
    if (!now) @(negedge clk);
    mcand = a; mplier = b; startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    waitDone();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs during reset
    check("R1", "busy in reset", busy, 0);
    check("R1", "done in reset", done, 0);
    check("R1", "product in reset", {prodHi, prodLo}, 0);
    rstN = 1'b1;
    running = 1'b1;
    repeat (2) @(negedge clk);
    check("R1", "product after reset", {prodHi, prodLo}, 0);

    // R2 R3 R4: stated examples, positive and mixed sign
    phaseTag = "R2";
    doOp(4'b0010, 4'b0110, 1'b0);
    check("R4", "2 x 6", {prodHi, prodLo}, 8'h0C);
    doOp(4'b0010, 4'b1101, 1'b0);
    check("R4", "2 x -3", {prodHi, prodLo}, 8'hFA);

    // R6: most negative operands
    phaseTag = "R6";
    doOp(4'b1000, 4'b1000, 1'b0);
    check("R6", "-8 x -8", {prodHi, prodLo}, 8'h40);
    doOp(4'b1000, 4'b0001, 1'b0);
    check("R6", "-8 x 1", {prodHi, prodLo}, 8'hF8);
    doOp(4'b0111, 4'b1000, 1'b0);
    check("R6", "7 x -8", {prodHi, prodLo}, 8'hC8);

    // R8: new request raised in the done cycle
    phaseTag = "R8";
    doOp(4'b0011, 4'b0101, 1'b1);
    check("R8", "3 x 5 back to back", {prodHi, prodLo}, 8'h0F);
    doOp(4'b1111, 4'b1111, 1'b1);
    check("R8", "-1 x -1 back to back", {prodHi, prodLo}, 8'h01);

    // R5: requests with other operands while busy are ignored
    phaseTag = "R5";
    @(negedge clk);
    mcand = 4'b0101; mplier = 4'b1010; startReq = 1'b1;
    @(negedge clk);
    mcand = 4'b1111; mplier = 4'b0111;
    repeat (2) @(negedge clk);
    startReq = 1'b0;
    waitDone();
    check("R5", "5 x -6 with busy noise", {prodHi, prodLo}, 8'hE2);

    // R9: idle with operand changes and no request
    phaseTag = "R9";
    mcand = 4'b0110; mplier = 4'b0110;
    repeat (4) @(negedge clk);
    check("R9", "idle hold", {prodHi, prodLo}, 8'hE2);

    // R4: every operand pair
    phaseTag = "R4";
    for (int a = 0; a < (1 << W); a++) begin
      for (int b = 0; b < (1 << W); b++) begin
        doOp(W'(a), W'(b), 1'b0);
      end
    end

    repeat (3) @(negedge clk);
    running = 1'b0;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule